// File: doc/BRIEF.md
# IN Endpoint Ping-Pong Packet Buffer

This block holds outgoing packets for one IN endpoint of a USB device. It sits between the application, which writes packet bytes, and the serial engine, which sends them to the host. It has one or two banks. With two banks they alternate, so the application can fill one bank while the other waits for the host or is being sent. Each bank holds up to one maximum-size packet and keeps its own byte count.

The application may write only while the packet-ready flag reads low. After it writes a packet, it seals the bank with a set strobe. In auto-valid mode the hardware seals a bank by itself once the bank holds a full maximum-size packet. A short or zero-length packet always needs the set strobe. The serial engine always reads from the oldest sealed bank. An IN token that finds no sealed bank gets a NAK. A sealed bank becomes free only when the host acknowledges it. Without that acknowledgement the bank is kept, and the next token replays it from its first byte. A level interrupt signals that the current write bank is free. It is enabled and masked by two separate strobes. A flush strobe empties the block.

Top module: `in_ep_bankbuf`

## Requirements
- R1: After reset, app_pkt_rdy, sie_has_pkt, app_irq and sie_nak are all 0.
- R2: A pulse on app_set_rdy seals the current write bank. The serial side then shows sie_has_pkt=1 and sie_len equal to the number of bytes written, and sie_rd returns those bytes in write order on sie_rdata one cycle after each read strobe.
- R3: While app_pkt_rdy is 1, app_wr has no effect on any bank's contents or count.
- R4: With cfg_auto_valid=1, the write that brings a bank to MAX_PKT bytes seals it with sie_len=MAX_PKT. With cfg_auto_valid=0 a full bank stays open, and writes beyond MAX_PKT are dropped.
- R5: With two banks, sealing one bank clears app_pkt_rdy so that the other bank can be filled, and the serial side presents banks oldest first.
- R6: An sie_in_token pulse while sie_has_pkt is 0 gives a one-cycle sie_nak pulse in the next cycle. A token while a packet is waiting gives no NAK.
- R7: A token with no following sie_ack keeps the bank sealed, and the next reads restart from byte 0.
- R8: An sie_ack pulse while a packet is waiting frees that bank and moves the serial side to the next bank.
- R9: app_irq is 1 exactly when the interrupt is enabled and app_pkt_rdy is 0. app_int_en_set enables the interrupt and app_int_en_clr masks it.
- R10: A flush pulse empties every bank, clears app_pkt_rdy and sets the write byte position back to 0.
- R11: A set strobe with no bytes written seals a zero-length packet, shown as sie_has_pkt=1 with sie_len=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_auto_valid | input | 1 | Seal full banks automatically |
| app_wr | input | 1 | Write one byte into the current bank |
| app_wdata | input | DW | Byte to write |
| app_set_rdy | input | 1 | Seal the current bank (set strobe) |
| app_int_en_set | input | 1 | Enable the bank-free interrupt |
| app_int_en_clr | input | 1 | Mask the bank-free interrupt |
| flush | input | 1 | Empty all banks |
| app_pkt_rdy | output | 1 | Current write bank is sealed; writes are blocked |
| app_irq | output | 1 | Bank-free interrupt |
| sie_in_token | input | 1 | IN token received |
| sie_rd | input | 1 | Read the next byte of the oldest sealed bank |
| sie_ack | input | 1 | Host acknowledged the packet |
| sie_has_pkt | output | 1 | A sealed bank is waiting |
| sie_len | output | $clog2(MAX_PKT+1) | Byte count of the oldest sealed bank |
| sie_rdata | output | DW | Byte read |
| sie_nak | output | 1 | NAK response to the token |

## Verification
A lost or stuck bank-valid bit shows at the ports within one cycle. app_pkt_rdy, app_irq or sie_has_pkt then disagree with the count of seals and acknowledgements. A wrong write-bank or read-bank pointer shows as the wrong length or the wrong first byte on the next packet the serial side presents. A write or read pointer that is not cleared on a seal, a token or a flush shows on the next read as shifted data or as a wrong length.

// File: rtl/in_ep_bankbuf.sv
module in_ep_bankbuf #(
  parameter int MAX_PKT = 64,
  parameter int NBANKS  = 2,
  parameter int DW      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_auto_valid,
  input  logic                         app_wr,
  input  logic [DW-1:0]                app_wdata,
  input  logic                         app_set_rdy,
  input  logic                         app_int_en_set,
  input  logic                         app_int_en_clr,
  input  logic                         flush,
  output logic                         app_pkt_rdy,
  output logic                         app_irq,
  input  logic                         sie_in_token,
  input  logic                         sie_rd,
  input  logic                         sie_ack,
  output logic                         sie_has_pkt,
  output logic [$clog2(MAX_PKT+1)-1:0] sie_len,
  output logic [DW-1:0]                sie_rdata,
  output logic                         sie_nak
);
  localparam int CW    = $clog2(MAX_PKT + 1);
  localparam int DEPTH = MAX_PKT * NBANKS;
  localparam int AD    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]     mem [DEPTH];
  logic [NBANKS-1:0] valid;
  logic [CW-1:0]     cnt [NBANKS];
  logic              wr_bank, rd_bank, int_en;
  logic [CW-1:0]     wr_ptr, rd_ptr;

  function automatic logic next_bank(input logic b);
    return (NBANKS == 2) ? ~b : 1'b0;
  endfunction

  logic          wr_ok, auto_fire, seal, free, rd_ok;
  logic [CW-1:0] wr_cnt;
  logic [AD-1:0] wr_addr, rd_addr;

  assign app_pkt_rdy = valid[wr_bank];
  assign sie_has_pkt = valid[rd_bank];
  assign sie_len     = cnt[rd_bank];
  assign app_irq     = int_en & ~app_pkt_rdy;

  assign wr_ok     = app_wr & ~valid[wr_bank] & (wr_ptr < CW'(MAX_PKT));
  assign wr_cnt    = wr_ptr + CW'(wr_ok);
  assign auto_fire = wr_ok & cfg_auto_valid & (wr_cnt == CW'(MAX_PKT));
  assign seal      = ~valid[wr_bank] & (app_set_rdy | auto_fire);
  assign free      = sie_ack & valid[rd_bank];
  assign rd_ok     = sie_rd & valid[rd_bank] & (rd_ptr < cnt[rd_bank]);
  assign wr_addr   = AD'(int'(wr_bank) * MAX_PKT + int'(wr_ptr));
  assign rd_addr   = AD'(int'(rd_bank) * MAX_PKT + int'(rd_ptr));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= app_wdata;
    if (rd_ok) sie_rdata <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int b = 0; b < NBANKS; b++) cnt[b] <= '0;
    end else if (flush) begin
      valid <= '0;
    end else begin
      for (int b = 0; b < NBANKS; b++) begin
        if (free && int'(rd_bank) == b) valid[b] <= 1'b0;
        if (seal && int'(wr_bank) == b) begin
          valid[b] <= 1'b1;
          cnt[b]   <= wr_cnt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      wr_ptr  <= '0;
    end else if (flush) begin
      wr_bank <= 1'b0;
      wr_ptr  <= '0;
    end else if (seal) begin
      wr_bank <= next_bank(wr_bank);
      wr_ptr  <= '0;
    end else if (wr_ok) begin
      wr_ptr  <= wr_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank <= 1'b0;
      rd_ptr  <= '0;
      sie_nak <= 1'b0;
    end else begin
      sie_nak <= sie_in_token & ~valid[rd_bank] & ~flush;
      if (flush) begin
        rd_bank <= 1'b0;
        rd_ptr  <= '0;
      end else if (free) begin
        rd_bank <= next_bank(rd_bank);
        rd_ptr  <= '0;
      end else if (sie_in_token) begin
        rd_ptr  <= '0;
      end else if (rd_ok) begin
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              int_en <= 1'b0;
    else if (app_int_en_clr) int_en <= 1'b0;
    else if (app_int_en_set) int_en <= 1'b1;
  end

  assert_nak_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sie_nak |-> !$past(sie_has_pkt));
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sie_has_pkt |-> sie_len <= CW'(MAX_PKT));
  assert_wr_ptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= CW'(MAX_PKT));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!sie_has_pkt && !app_pkt_rdy));
  assert_ack_frees_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !seal && !flush) |=> $countones(valid) == $past($countones(valid)) - 1);
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    app_int_en_clr |=> !app_irq);
endmodule

// File: tb/tb_in_ep_bankbuf.sv
module tb_in_ep_bankbuf;
  localparam int MP = 8;
  localparam int CW = $clog2(MP + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_auto_valid = 0, app_wr = 0, app_set_rdy = 0;
  logic app_int_en_set = 0, app_int_en_clr = 0, flush = 0;
  logic [7:0] app_wdata = 0;
  logic sie_in_token = 0, sie_rd = 0, sie_ack = 0;
  logic app_pkt_rdy, app_irq, sie_has_pkt, sie_nak;
  logic [CW-1:0] sie_len;
  logic [7:0] sie_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  in_ep_bankbuf #(.MAX_PKT(MP), .NBANKS(2), .DW(8)) dut (
    .clk, .rst_n, .cfg_auto_valid, .app_wr, .app_wdata, .app_set_rdy,
    .app_int_en_set, .app_int_en_clr, .flush, .app_pkt_rdy, .app_irq,
    .sie_in_token, .sie_rd, .sie_ack, .sie_has_pkt, .sie_len, .sie_rdata, .sie_nak);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    app_wr = 1; app_wdata = d; @(negedge clk); app_wr = 0;
  endtask
  task automatic set_rdy; app_set_rdy = 1; @(negedge clk); app_set_rdy = 0; endtask
  task automatic ack;     sie_ack = 1;     @(negedge clk); sie_ack = 0;     endtask
  task automatic token;   sie_in_token = 1; @(negedge clk); sie_in_token = 0; endtask
  task automatic do_flush; flush = 1;      @(negedge clk); flush = 0;       endtask
  task automatic rd(output logic [7:0] v);
    sie_rd = 1; @(negedge clk); sie_rd = 0; v = sie_rdata;
  endtask

  task automatic t_reset;
    chk("R1 pkt_rdy", app_pkt_rdy, 0);
    chk("R1 has_pkt", sie_has_pkt, 0);
    chk("R1 irq", app_irq, 0);
    chk("R1 nak", sie_nak, 0);
  endtask

  task automatic t_short;
    logic [7:0] v;
    for (int i = 0; i < 3; i++) wr(8'h11 + 8'(i));
    chk("R2 no packet before set", sie_has_pkt, 0);
    set_rdy();
    chk("R2 has_pkt", sie_has_pkt, 1);
    chk("R2 len", sie_len, 3);
    token();
    chk("R6 no nak with packet", sie_nak, 0);
    for (int i = 0; i < 3; i++) begin
      rd(v);
      chk("R2 data order", v, 8'h11 + i);
    end
    ack();
    chk("R8 freed", sie_has_pkt, 0);
  endtask

  task automatic t_nak;
    token();
    chk("R6 nak pulse", sie_nak, 1);
    @(negedge clk);
    chk("R6 nak one cycle", sie_nak, 0);
  endtask

  task automatic t_pingpong;
    logic [7:0] v;
    wr(8'hA0); wr(8'hA1); set_rdy();
    chk("R5 second bank open", app_pkt_rdy, 0);
    for (int i = 0; i < 4; i++) wr(8'hB0 + 8'(i));
    set_rdy();
    chk("R5 both full", app_pkt_rdy, 1);
    wr(8'hEE); wr(8'hEF);
    chk("R5 oldest first len", sie_len, 2);
    rd(v); chk("R5 oldest first data", v, 8'hA0);
    ack();
    chk("R8 next bank len", sie_len, 4);
    chk("R3 blocked writes left count", sie_len, 4);
    for (int i = 0; i < 4; i++) begin
      rd(v); chk("R3 data intact", v, 8'hB0 + i);
    end
    token(); rd(v);
    chk("R7 replay byte0", v, 8'hB0);
    rd(v);
    token();
    chk("R7 kept without ack", sie_has_pkt, 1);
    rd(v);
    chk("R7 restart after retry", v, 8'hB0);
    ack();
    chk("R8 all free", sie_has_pkt, 0);
    chk("R8 write bank free", app_pkt_rdy, 0);
    set_rdy();
    chk("R11 zero length valid", sie_has_pkt, 1);
    chk("R11 zero length len / R3 nothing stored", sie_len, 0);
    ack();
  endtask

  task automatic t_auto;
    cfg_auto_valid = 1;
    for (int i = 0; i < MP - 1; i++) wr(8'(i));
    chk("R4 not sealed early", sie_has_pkt, 0);
    wr(8'h77);
    chk("R4 auto sealed", sie_has_pkt, 1);
    chk("R4 auto len", sie_len, MP);
    chk("R4 other bank open", app_pkt_rdy, 0);
    ack();
    cfg_auto_valid = 0;
    for (int i = 0; i < MP + 2; i++) wr(8'(i));
    chk("R4 no auto seal", sie_has_pkt, 0);
    set_rdy();
    chk("R4 overflow dropped", sie_len, MP);
    ack();
  endtask

  task automatic t_irq;
    chk("R9 masked at start", app_irq, 0);
    app_int_en_set = 1; @(negedge clk); app_int_en_set = 0;
    chk("R9 enabled", app_irq, 1);
    wr(8'h01); set_rdy(); wr(8'h02); set_rdy();
    chk("R9 low when full", app_irq, 0);
    ack();
    chk("R9 high on free", app_irq, 1);
    app_int_en_clr = 1; @(negedge clk); app_int_en_clr = 0;
    chk("R9 masked", app_irq, 0);
    ack();
  endtask

  task automatic t_flush;
    wr(8'h55); set_rdy(); wr(8'h66); wr(8'h67);
    do_flush();
    chk("R10 no packet", sie_has_pkt, 0);
    chk("R10 pkt_rdy clear", app_pkt_rdy, 0);
    set_rdy();
    chk("R10 write position cleared", sie_len, 0);
    do_flush();
    chk("R10 flushed again", sie_has_pkt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_short();
    t_nak();
    t_pingpong();
    t_auto();
    t_irq();
    t_flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule